// File: doc/BRIEF.md
# IrDA SIR Pulse Encoder

This block turns the transmit line of an asynchronous serial port into the short-pulse signalling that an infrared optical transceiver expects. The serial side sends ordinary UART frames. The encoder watches that line through a two-flop synchronizer. On a high-to-low transition it opens a frame of ten bit windows: one start bit, eight data bits and one stop bit. A free-running enable from a separate bit-clock generator, 16 ticks per bit time, times every window. All windows are counted from the single detected start edge.

Within each window the line level is sampled once, early in the window. If the sampled bit is zero, the infrared output goes high for a short pulse at a fixed offset into the window. If it is one, the output stays low for the whole window. When the stop window ends, the encoder goes back to idle and waits for the next falling edge. A low enable input abandons any frame in progress and forces the output low.

Top module: `irda_sir_encoder`

## Requirements
- R1: During reset and after it, while the serial line rests high, `ir_pulse` is low and no frame is in progress.
- R2: A frame opens on a falling edge of the synchronized serial line. The first pulse rises 7 ticks after the frame opens, which is 7 to 8 ticks after the line fell once the synchronizer delay is included.
- R3: The line is sampled at tick 4 of each 16-tick window, with ticks counted 0 to 15. A sampled zero gives exactly one pulse, high from tick 7 through tick 9 of that window, so 3 ticks wide.
- R4: A sampled one gives no pulse: `ir_pulse` stays low for the whole window.
- R5: A frame is ten windows of 16 ticks, in this order: start, data bits least significant bit first, stop. Every pulse of a frame starts an exact multiple of 16 ticks after the first pulse.
- R6: The stop window is sampled like any other window. If the line stays low through the stop window, that window carries a pulse. The encoder then idles and sends nothing more until the line rises and falls again.
- R7: While `enable` is low, `ir_pulse` goes low within one clock, any open frame is dropped, and no frame opens. After `enable` returns, a new falling edge is needed to open a frame.
- R8: Falling edges inside an open frame do not restart it. After the stop window the encoder accepts the next frame, even when that frame follows after only two ticks of idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Encoder enable; low forces idle and a low output |
| bit_tick | input | 1 | One-cycle tick, 16 per bit time |
| uart_tx | input | 1 | Asynchronous serial transmit line, idles high |
| ir_pulse | output | 1 | Pulse output to the optical transceiver |

## Verification
The bench builds the encoder with its default parameters: 16 ticks per bit, the sample at tick 4, and a pulse from tick 7 that is 3 ticks wide. It drives one tick every fourth clock, so each pulse lasts 12 clocks and each window 64 clocks. Because the tick phase is not tied to the serial edge, the start-edge jitter can be seen, while pulse spacing and width stay exact multiples of the tick. The same setup brings within reach several cases: a line stuck low through the stop window, a disable in the middle of a pulse, and a frame that follows the previous stop after only two ticks.

// File: rtl/irda_sir_encoder.sv
module irda_sir_encoder #(
  parameter int TICKS_PER_BIT = 16,
  parameter int SAMPLE_TICK   = 4,
  parameter int PULSE_START   = 7,
  parameter int PULSE_TICKS   = 3,
  parameter int DATA_BITS     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic bit_tick,
  input  logic uart_tx,
  output logic ir_pulse
);
  localparam int TW          = $clog2(TICKS_PER_BIT);
  localparam int NWIN        = DATA_BITS + 2;
  localparam int BW          = $clog2(NWIN);
  localparam int PULSE_END   = PULSE_START + PULSE_TICKS;
  localparam int FRAME_TICKS = TICKS_PER_BIT * NWIN;
  localparam int FW          = $clog2(FRAME_TICKS + 1);

  logic [1:0]    tx_sync;
  logic          tx_prev;
  logic          busy;
  logic          bit_lvl;
  logic [TW-1:0] tcnt;
  logic [BW-1:0] widx;
  logic          tx_fall;
  logic          in_pulse;

  assign tx_fall  = tx_prev & ~tx_sync[1];
  assign in_pulse = (tcnt >= TW'(PULSE_START)) && (tcnt < TW'(PULSE_END));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sync <= 2'b11;
      tx_prev <= 1'b1;
    end else begin
      tx_sync <= {tx_sync[0], uart_tx};
      tx_prev <= tx_sync[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      busy     <= 1'b0;
      tcnt     <= '0;
      widx     <= '0;
      bit_lvl  <= 1'b1;
      ir_pulse <= 1'b0;
    end else begin
      if (!busy) begin
        busy    <= tx_fall;
        tcnt    <= '0;
        widx    <= '0;
        bit_lvl <= 1'b1;
      end else if (bit_tick) begin
        if (tcnt == TW'(SAMPLE_TICK - 1)) bit_lvl <= tx_sync[1];
        if (tcnt == TW'(TICKS_PER_BIT - 1)) begin
          tcnt    <= '0;
          bit_lvl <= 1'b1;
          if (widx == BW'(NWIN - 1)) busy <= 1'b0;
          else widx <= widx + 1'b1;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
      ir_pulse <= busy && !bit_lvl && in_pulse;
    end
  end

  logic [7:0]    hi_cnt;
  logic [FW-1:0] fr_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      fr_cnt <= '0;
    end else begin
      hi_cnt <= ir_pulse ? hi_cnt + {7'd0, bit_tick} : 8'd0;
      fr_cnt <= busy ? fr_cnt + {{(FW-1){1'b0}}, bit_tick} : '0;
    end
  end

  a_r7_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !ir_pulse);

  a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ir_pulse) && enable && $past(enable) |-> hi_cnt == 8'(PULSE_TICKS));

  a_r5_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && $past(enable) |-> fr_cnt == FW'(FRAME_TICKS));

  a_r4_pulse_only_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_pulse) |-> $past(busy) && !$past(bit_lvl));

  a_r1_idle_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !tx_fall |=> !busy);
endmodule

// File: tb/tb_irda_sir_encoder.sv
module tb_irda_sir_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CYC    = 16 * TICK_DIV;
  localparam int BIT_NS     = BIT_CYC * CLK_PERIOD;
  localparam int PULSE_NS   = 3 * TICK_DIV * CLK_PERIOD;
  localparam logic [11:0] VEC [0:5] = '{12'h009, 12'hFF1, 12'h555,
                                        12'hA55, 12'h817, 12'h3C5};

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b1, bit_tick = 1'b0, uart_tx = 1'b1;
  logic ir_pulse;
  int total = 0, bad = 0, div = 0;
  int n = 0;
  time rises [0:15];
  time widths [0:15];
  time t_fall;
  logic last_ir = 1'b0;

  irda_sir_encoder dut (.clk(clk), .rst_n(rst_n), .enable(enable),
    .bit_tick(bit_tick), .uart_tx(uart_tx), .ir_pulse(ir_pulse));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    div = (div == TICK_DIV - 1) ? 0 : div + 1;
    bit_tick = (div == 0);
  end

  always @(negedge clk) begin
    if (ir_pulse && !last_ir && n < 16) begin
      rises[n] = $time;
      n = n + 1;
    end
    if (!ir_pulse && last_ir && n > 0) widths[n-1] = $time - rises[n-1];
    last_ir = ir_pulse;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic lvl, input int cycles);
    @(negedge clk);
    uart_tx = lvl;
    repeat (cycles - 1) @(negedge clk);
  endtask

  task automatic clear_mon();
    @(posedge clk);
    n = 0;
  endtask

  task automatic send_frame(input logic [7:0] d, input int gap);
    @(negedge clk);
    t_fall = $time;
    uart_tx = 1'b0;
    repeat (BIT_CYC - 1) @(negedge clk);
    for (int i = 0; i < 8; i++) drive(d[i], BIT_CYC);
    drive(1'b1, BIT_CYC);
    repeat (gap) @(negedge clk);
  endtask

  task automatic check_pulses(input int exp_pos [0:15], input int e, input string tag);
    bit sp_ok = 1, w_ok = 1;
    longint sp_bad = 0, w_bad = 0;
    check(n == e, {tag, " pulse count R3 R4"}, n, e);
    if (n > 0)
      check(rises[0] - t_fall >= 7*TICK_DIV*CLK_PERIOD && rises[0] - t_fall <= 8*TICK_DIV*CLK_PERIOD,
            {tag, " first pulse delay R2"}, rises[0] - t_fall, 7*TICK_DIV*CLK_PERIOD);
    for (int i = 0; i < n && i < e; i++) begin
      if (rises[i] - rises[0] != longint'(exp_pos[i]) * BIT_NS) begin
        sp_ok = 0; sp_bad = rises[i] - rises[0];
      end
      if (widths[i] != PULSE_NS) begin
        w_ok = 0; w_bad = widths[i];
      end
    end
    check(sp_ok, {tag, " pulse spacing R5"}, sp_bad, 0);
    check(w_ok, {tag, " pulse width R3"}, w_bad, PULSE_NS);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired R1 actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int pos [0:15];
    int e;
    int nb;
    repeat (5) @(negedge clk);
    check(ir_pulse == 1'b0, "R1 output low in reset", ir_pulse, 0);
    rst_n = 1'b1;
    repeat (200) @(negedge clk);
    check(ir_pulse == 1'b0 && n == 0, "R1 quiet idle after reset", n, 0);

    foreach (VEC[k]) begin
      clear_mon();
      send_frame(VEC[k][11:4], 8);
      e = 1; pos[0] = 0;
      for (int i = 0; i < 8; i++) if (!VEC[k][4+i]) begin pos[e] = i + 1; e++; end
      check(e == int'(VEC[k][3:0]), "R4 table pulse count", e, VEC[k][3:0]);
      check_pulses(pos, int'(VEC[k][3:0]), $sformatf("R8 vector %0d", k));
    end

    clear_mon();
    @(negedge clk);
    t_fall = $time;
    uart_tx = 1'b0;
    repeat (12 * BIT_CYC) @(negedge clk);
    for (int i = 0; i < 10; i++) pos[i] = i;
    check_pulses(pos, 10, "R6 stuck low");
    drive(1'b1, 1);
    repeat (11 * BIT_CYC) @(negedge clk);
    check(n == 10, "R6 no pulse after stuck line", n, 10);

    clear_mon();
    @(negedge clk);
    uart_tx = 1'b0;
    repeat (2 * BIT_CYC + 40) @(negedge clk);
    check(ir_pulse == 1'b1, "R7 pulse active before disable", ir_pulse, 1);
    enable = 1'b0;
    @(negedge clk);
    check(ir_pulse == 1'b0, "R7 output drops when disabled", ir_pulse, 0);
    nb = n;
    repeat (8 * BIT_CYC) @(negedge clk);
    uart_tx = 1'b1;
    repeat (BIT_CYC) @(negedge clk);
    send_frame(8'h00, 8);
    check(n == nb, "R7 no pulses while disabled", n, nb);
    enable = 1'b1;
    repeat (11 * BIT_CYC) @(negedge clk);
    check(n == nb, "R7 no frame after re-enable without edge", n, nb);

    clear_mon();
    send_frame(8'h5A, 8);
    pos[0] = 0; pos[1] = 1; pos[2] = 3; pos[3] = 6; pos[4] = 8;
    check_pulses(pos, 5, "R7 recovery frame");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule